// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block sits on the local-bus side of a host bridge. It takes each 32-bit local-bus address and decides whether the address falls inside one of three programmable apertures into PCI space. For a hit it returns the PCI address that the bridge should drive, the PCI cycle type and a prefetchable hint. It does not generate bus cycles and does not move data.

Two apertures are general memory windows. Each has a base register with a power-of-two size code and a map register. The third aperture is a fixed 16 MB I/O window. Apertures may overlap, and the lowest-numbered matching aperture always supplies the translation. Software can therefore enlarge window 0 so that it hides window 1, then reprogram window 1 for another use, such as configuration cycles, without a gap in the memory mapping.

Registers are loaded through a single write port. A lookup is presented with `lb_valid`, and its result appears on the outputs one clock later.

Top module: `lb_window_xlate`

## Requirements
- R1: After reset every window is disabled, `res_valid` and `res_hit` are 0, and any lookup misses.
- R2: A lookup presented with `lb_valid` high at a clock edge produces `res_valid` high for exactly the following cycle. A cycle with `lb_valid` low produces `res_valid` low one cycle later.
- R3: A memory window's base register holds local address bits 31..20 in bits 31..20. Its 4-bit size code in bits 7..4 gives a size of 2^(20+code) bytes. The window hits when local bits 31..(20+code) equal the same base bits.
- R4: A memory window whose size code is greater than 11 never hits.
- R5: A window whose enable bit (bit 0 of its base register) is 0 never hits.
- R6: When several windows hit, the one with the lowest index is reported (memory windows 0 and 1, then the I/O window as index 2).
- R7: A memory-window result address takes map bits 15..4 as PCI bits 31..20 above the window size, and the local address bits below the window size.
- R8: When map bit 0 (low-address enable) is 0, result address bits 1..0 are 0. When it is 1, they come from the local address.
- R9: A memory-window result takes its cycle type from map bits 3..1 (000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration, 110 memory multiple) and its prefetchable flag from base bit 3.
- R10: The I/O window (index 2) hits when local bits 31..24 equal its base bits 15..8. Its result replaces those bits with map bits 15..8, keeps local bits 23..0, and carries cycle type 001 with the prefetchable flag 0.
- R11: A lookup that misses, and every cycle without a result, shows `res_hit`, `res_win`, `res_addr`, `res_ctype` and `res_pref` all 0.
- R12: `cfg_sel` selects the register written: 0 base0, 1 map0, 2 base1, 3 map1, 4 I/O base, 5 I/O map. Other codes write nothing. A write takes effect for lookups presented from the next cycle on. A lookup in the same cycle as a write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (see R12) |
| cfg_wdata | input | 32 | Write data; map and I/O registers use bits 15..0 |
| lb_valid | input | 1 | Lookup request |
| lb_addr | input | 32 | Local-bus address to translate |
| res_valid | output | 1 | Result of the previous cycle's lookup |
| res_hit | output | 1 | A window matched |
| res_win | output | 2 | Index of the matching window |
| res_addr | output | 32 | Translated PCI address |
| res_ctype | output | 3 | PCI cycle type |
| res_pref | output | 1 | Prefetchable hint |

## Verification
A corrupted window register shows up on the very next lookup that touches it. The symptom is a wrong hit or miss, a wrong index, or a PCI address with the wrong upper bits, so every check samples the result registers one cycle after its request. A faulty priority chain only shows when windows overlap. For that reason the stimulus deliberately enlarges window 0 over window 1 and places window 1 over the I/O window. Size-code boundaries (0, 11, and 12) and the low-address enable bit are each probed, because a bad mask shifts or truncates the address bits that pass through.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [2:0] {
        CT_IACK    = 3'b000,
        CT_IO      = 3'b001,
        CT_MEM     = 3'b011,
        CT_CFG     = 3'b101,
        CT_MEMMULT = 3'b110
    } cyc_type_e;

    // field positions shared by the window decoders
    localparam int BASE_EN_BIT   = 0;
    localparam int BASE_PREF_BIT = 3;
    localparam int SIZE_LSB      = 4;
    localparam int SIZE_W        = 4;
    localparam int MAP_LOWEN_BIT = 0;
    localparam int MAP_TYPE_LSB  = 1;
    localparam int MAP_ADDR_LSB  = 4;

endpackage

// File: rtl/xlate_mem_window.sv
module xlate_mem_window
    import xlate_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MIN_SHIFT = 20,
    parameter int CODE_MAX  = 11
) (
    input  logic [ADDR_W-1:0] base_reg,
    input  logic [15:0]       map_reg,
    input  logic [ADDR_W-1:0] lb_addr,
    output logic              hit,
    output logic [ADDR_W-1:0] pci_addr,
    output logic [2:0]        ctype,
    output logic              pref
);
    localparam int MAP_BITS = ADDR_W - MIN_SHIFT;

    logic [SIZE_W-1:0] code;
    logic [ADDR_W-1:0] keep;
    logic [ADDR_W-1:0] map_base;

    always_comb begin
        code     = base_reg[SIZE_LSB +: SIZE_W];
        keep     = {ADDR_W{1'b1}} << (MIN_SHIFT + int'(code));
        map_base = ADDR_W'(map_reg[MAP_ADDR_LSB +: MAP_BITS]) << MIN_SHIFT;
        hit      = base_reg[BASE_EN_BIT] && (int'(code) <= CODE_MAX)
                   && (((lb_addr ^ base_reg) & keep) == '0);
        pci_addr = (map_base & keep) | (lb_addr & ~keep);
        if (!map_reg[MAP_LOWEN_BIT])
            pci_addr[1:0] = 2'b00;
        ctype    = map_reg[MAP_TYPE_LSB +: 3];
        pref     = base_reg[BASE_PREF_BIT];
    end

    always_comb begin
        if (hit) assert_size_legal_R4: assert (int'(code) <= CODE_MAX);
        if (hit) assert_enabled_R5: assert (base_reg[BASE_EN_BIT]);
    end
endmodule

// File: rtl/xlate_io_window.sv
module xlate_io_window
    import xlate_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IO_SHIFT = 24
) (
    input  logic [15:0]       base_reg,
    input  logic [15:0]       map_reg,
    input  logic [ADDR_W-1:0] lb_addr,
    output logic              hit,
    output logic [ADDR_W-1:0] pci_addr,
    output logic [2:0]        ctype,
    output logic              pref
);
    localparam int TOP_W = ADDR_W - IO_SHIFT;

    always_comb begin
        hit      = base_reg[BASE_EN_BIT]
                   && (lb_addr[ADDR_W-1:IO_SHIFT] == base_reg[15 -: TOP_W]);
        pci_addr = {map_reg[15 -: TOP_W], lb_addr[IO_SHIFT-1:0]};
        ctype    = CT_IO;
        pref     = 1'b0;
    end
endmodule

// File: rtl/xlate_prio.sv
module xlate_prio #(
    parameter int N      = 3,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic [N-1:0]            hit_v,
    input  logic [N-1:0][ADDR_W-1:0] addr_v,
    input  logic [N-1:0][2:0]       ctype_v,
    input  logic [N-1:0]            pref_v,
    output logic                    found,
    output logic [IDX_W-1:0]        idx,
    output logic [ADDR_W-1:0]       addr,
    output logic [2:0]              ctype,
    output logic                    pref
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        addr  = '0;
        ctype = '0;
        pref  = 1'b0;
        // scan downward so the lowest index is applied last and wins
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                addr  = addr_v[i];
                ctype = ctype_v[i];
                pref  = pref_v[i];
            end
        end
    end
endmodule

// File: rtl/lb_window_xlate.sv
module lb_window_xlate
    import xlate_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_MEM   = 2,
    parameter int MIN_SHIFT = 20,
    parameter int CODE_MAX  = 11,
    parameter int IO_SHIFT  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              lb_valid,
    input  logic [ADDR_W-1:0] lb_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [1:0]        res_win,
    output logic [ADDR_W-1:0] res_addr,
    output logic [2:0]        res_ctype,
    output logic              res_pref
);
    localparam int NWIN   = NUM_MEM + 1;
    localparam int IDX_W  = $clog2(NWIN);
    localparam int IO_IDX = NUM_MEM;

    typedef struct packed {
        logic [NUM_MEM-1:0][ADDR_W-1:0] mem_base;
        logic [NUM_MEM-1:0][15:0]       mem_map;
        logic [15:0]                    io_base;
        logic [15:0]                    io_map;
    } cfg_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  win;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        ctype;
        logic              pref;
    } res_t;

    cfg_t cfg_d, cfg_q;
    res_t res_d, res_q;

    logic [NWIN-1:0]             hit_v;
    logic [NWIN-1:0][ADDR_W-1:0] addr_v;
    logic [NWIN-1:0][2:0]        ctype_v;
    logic [NWIN-1:0]             pref_v;
    logic                        found;
    logic [IDX_W-1:0]            sel_idx;
    logic [ADDR_W-1:0]           sel_addr;
    logic [2:0]                  sel_ctype;
    logic                        sel_pref;

    for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
        xlate_mem_window #(
            .ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT), .CODE_MAX(CODE_MAX)
        ) win_i (
            .base_reg (cfg_q.mem_base[g]),
            .map_reg  (cfg_q.mem_map[g]),
            .lb_addr  (lb_addr),
            .hit      (hit_v[g]),
            .pci_addr (addr_v[g]),
            .ctype    (ctype_v[g]),
            .pref     (pref_v[g])
        );
    end

    xlate_io_window #(.ADDR_W(ADDR_W), .IO_SHIFT(IO_SHIFT)) io_i (
        .base_reg (cfg_q.io_base),
        .map_reg  (cfg_q.io_map),
        .lb_addr  (lb_addr),
        .hit      (hit_v[IO_IDX]),
        .pci_addr (addr_v[IO_IDX]),
        .ctype    (ctype_v[IO_IDX]),
        .pref     (pref_v[IO_IDX])
    );

    xlate_prio #(.N(NWIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) prio_i (
        .hit_v   (hit_v),
        .addr_v  (addr_v),
        .ctype_v (ctype_v),
        .pref_v  (pref_v),
        .found   (found),
        .idx     (sel_idx),
        .addr    (sel_addr),
        .ctype   (sel_ctype),
        .pref    (sel_pref)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int i = 0; i < NUM_MEM; i++) begin
                if (int'(cfg_sel) == 2 * i)     cfg_d.mem_base[i] = ADDR_W'(cfg_wdata);
                if (int'(cfg_sel) == 2 * i + 1) cfg_d.mem_map[i]  = cfg_wdata[15:0];
            end
            if (int'(cfg_sel) == 2 * NUM_MEM)     cfg_d.io_base = cfg_wdata[15:0];
            if (int'(cfg_sel) == 2 * NUM_MEM + 1) cfg_d.io_map  = cfg_wdata[15:0];
        end

        res_d       = '0;
        res_d.valid = lb_valid;
        if (lb_valid && found) begin
            res_d.hit   = 1'b1;
            res_d.win   = sel_idx;
            res_d.addr  = sel_addr;
            res_d.ctype = sel_ctype;
            res_d.pref  = sel_pref;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            res_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_win   = 2'(res_q.win);
    assign res_addr  = res_q.addr;
    assign res_ctype = res_q.ctype;
    assign res_pref  = res_q.pref;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lb_valid |=> res_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lb_valid |=> !res_valid);
    assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_addr == '0 && res_ctype == 3'b000 && res_win == 2'd0 && !res_pref));
    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && res_win != 2'd0) |-> !$past(hit_v[0]));
    assert_io_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && res_win == 2'(IO_IDX)) |-> (res_ctype == 3'b001 && !res_pref));
    assert_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && res_win == 2'd0 && !$past(cfg_q.mem_map[0][MAP_LOWEN_BIT]))
        |-> res_addr[1:0] == 2'b00);
    assert_win0_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && res_win == 2'd0)
        |-> (int'($past(cfg_q.mem_base[0][SIZE_LSB +: SIZE_W])) <= CODE_MAX
             && $past(cfg_q.mem_base[0][BASE_EN_BIT])));
endmodule

// File: tb/lb_window_xlate_tb_top.sv
module lb_window_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lb_valid = 1'b0;
    logic [31:0] lb_addr = '0;
    logic        res_valid, res_hit, res_pref;
    logic [1:0]  res_win;
    logic [31:0] res_addr;
    logic [2:0]  res_ctype;

    int checks = 0;
    int bad = 0;

    typedef struct packed {
        logic        hit;
        logic [1:0]  win;
        logic [31:0] addr;
        logic [2:0]  ct;
        logic        pref;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    lb_window_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lb_valid(lb_valid), .lb_addr(lb_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_win(res_win),
        .res_addr(res_addr), .res_ctype(res_ctype), .res_pref(res_pref)
    );

    // monitor: pops one expectation per result
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t  e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected result addr=%h expected none", res_addr);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({res_hit, res_win, res_addr, res_ctype, res_pref} !== e) begin
                    bad++;
                    $display("FAIL %s got hit=%b win=%0d addr=%h ct=%b pref=%b exp hit=%b win=%0d addr=%h ct=%b pref=%b",
                             t, res_hit, res_win, res_addr, res_ctype, res_pref,
                             e.hit, e.win, e.addr, e.ct, e.pref);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        lb_valid  = 1'b0;
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drives one lookup for one cycle; leaves lb_valid high for back-to-back use
    task automatic look(input logic [31:0] a, input logic h, input logic [1:0] w,
                        input logic [31:0] pa, input logic [2:0] ct, input logic p,
                        input string t);
        @(negedge clk);
        cfg_we   = 1'b0;
        lb_valid = 1'b1;
        lb_addr  = a;
        exp_q.push_back({h, w, pa, ct, p});
        tag_q.push_back(t);
    endtask

    task automatic idle();
        @(negedge clk);
        lb_valid = 1'b0;
        cfg_we   = 1'b0;
    endtask

    task automatic chk(input logic ok, input string t, input logic [31:0] got, input logic [31:0] ex);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", t, got, ex);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0 && res_hit == 1'b0, "R1 reset outputs", {30'd0, res_valid, res_hit}, 32'd0);
        rst_n = 1'b1;
        look(32'h4123_4567, 0, 0, 0, 0, 0, "R1 lookup after reset misses");
        idle();
        @(negedge clk);
        chk(res_valid == 1'b0, "R2 idle gives no result", {31'd0, res_valid}, 32'd0);
        chk(res_hit == 1'b0 && res_addr == 0, "R11 idle fields zero", res_addr, 32'd0);

        // window 0: 0x4000_0000 256MB -> 0x8000_0000 memory, low-enable off
        wr(3'd0, 32'h4000_0081);
        wr(3'd1, 32'h0000_8006);
        // window 1: 0x5000_0000 256MB prefetchable -> 0x9000_0000 mem multiple, low-enable on
        wr(3'd2, 32'h5000_0089);
        wr(3'd3, 32'h0000_900D);
        // I/O window: 0x60xx_xxxx -> 0xA5xx_xxxx
        wr(3'd4, 32'h0000_6001);
        wr(3'd5, 32'h0000_A500);
        wr(3'd7, 32'hFFFF_FFFF); // unused select: must change nothing (R12)

        look(32'h4123_4567, 1, 0, 32'h8123_4564, 3'b011, 0, "R3 R7 R8 window0 hit");
        look(32'h5ABC_DEF3, 1, 1, 32'h9ABC_DEF3, 3'b110, 1, "R9 R8 window1 hit");
        look(32'h6012_3457, 1, 2, 32'hA512_3457, 3'b001, 0, "R10 io window hit");
        look(32'h7000_0000, 0, 0, 0, 0, 0, "R11 miss");
        look(32'h6100_0000, 0, 0, 0, 0, 0, "R10 io upper byte mismatch");
        idle();

        // enlarge window 0 to 512MB: it hides window 1 (R6)
        wr(3'd0, 32'h4000_0091);
        look(32'h5ABC_DEF3, 1, 0, 32'h9ABC_DEF0, 3'b011, 0, "R6 enlarged window0 hides window1");
        idle();
        // window 1 as 16MB config window on top of the I/O window
        wr(3'd2, 32'h6000_0041);
        wr(3'd3, 32'h0000_000A);
        look(32'h6012_3457, 1, 1, 32'h0012_3454, 3'b101, 0, "R6 window1 beats io window");
        idle();

        // size code 12: never matches
        wr(3'd0, 32'h4000_00C1);
        look(32'h4123_4567, 0, 0, 0, 0, 0, "R4 size code 12 misses");
        idle();
        // disabled window
        wr(3'd0, 32'h4000_0080);
        look(32'h4123_4567, 0, 0, 0, 0, 0, "R5 disabled misses");
        idle();
        // size code 0 (1MB) boundaries
        wr(3'd0, 32'h4120_0001);
        look(32'h412F_FFFF, 1, 0, 32'h800F_FFFC, 3'b011, 0, "R3 1MB top edge");
        look(32'h4130_0000, 0, 0, 0, 0, 0, "R3 1MB just above");
        look(32'h411F_FFFF, 0, 0, 0, 0, 0, "R3 1MB just below");
        idle();
        // size code 11 (2GB)
        wr(3'd0, 32'h8000_00B1);
        look(32'hFFFF_FFFF, 1, 0, 32'hFFFF_FFFC, 3'b011, 0, "R3 R7 2GB window");
        look(32'h7FFF_FFFF, 0, 0, 0, 0, 0, "R3 2GB lower half misses");
        idle();

        // write in the same cycle as a lookup uses the old value (R12)
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 3'd4;
        cfg_wdata = 32'h0000_6201;
        lb_valid  = 1'b1;
        lb_addr   = 32'h6234_5678;
        exp_q.push_back({1'b0, 2'd0, 32'd0, 3'd0, 1'b0});
        tag_q.push_back("R12 same-cycle write uses old base");
        look(32'h6234_5678, 1, 2, 32'hA534_5678, 3'b001, 0, "R12 write visible next cycle");
        idle();
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all results returned", exp_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog expired got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule